// File: doc/BRIEF.md
# Stage Counter Branch Unit

This unit sits beside a small sequencing core and owns an 8-bit loop counter, the stage counter, which is kept apart from the general registers. The core hands it one decoded operation at a time. Each operation comes with an operand, a signed relative offset, the current program counter and the present value of register R0. The operations clear the counter, add to it, subtract from it, or perform a relative branch. A branch compares either the counter or R0 against a threshold carried in the instruction.

An operation is accepted when `start_i` is high at a rising clock edge while the unit is not busy. All operand inputs are sampled at that edge. The unit then spends two execute cycles, after which it raises `done_o` for one cycle and presents the branch decision and the next program counter. Those two results stay unchanged until the next completion. Instruction fetch and decode are outside the unit.

Top module: `scb_unit`

## Requirements
- R1: While and after reset (with no operation issued), `stage_cnt_o` is 0, `busy_o` is 0, `done_o` is 0, `taken_o` is 0 and `next_pc_o` is 0.
- R2: If `start_i` is high at a rising edge while `busy_o` is 0, `busy_o` reads 1 for the next two clock periods. `done_o` then reads 1, with `busy_o` back at 0, for exactly one period starting at the second rising edge after the accepting edge.
- R3: Operation code 0 (clear) sets the stage counter to 0 when `done_o` rises.
- R4: Operation code 1 adds `arg_i[7:0]` to the stage counter modulo 256. Operation code 2 subtracts `arg_i[7:0]` modulo 256. In both cases the new value appears when `done_o` rises.
- R5: Operation code 3 is the counter branch. It compares the stage counter, unsigned, against `arg_i[7:0]`. Condition code `cond_i` selects the test: 0 is taken when counter < threshold, 1 when counter > threshold, 2 when counter <= threshold, 3 when counter == threshold.
- R6: Operation code 4 is the R0 branch. It compares `r0_i`, unsigned 16-bit, against `arg_i`. With `cond_i[0]`=0 it is taken when R0 < threshold; with `cond_i[0]`=1 it is taken when R0 >= threshold.
- R7: When a branch is taken, `next_pc_o` is `pc_i` plus the sign-extended `rel_i`, modulo 2^11. Otherwise `next_pc_o` is `pc_i`+1 modulo 2^11. Operation codes 0 to 2 always report `taken_o`=0.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: it changes neither the counter nor the results of the operation in flight.
- R9: Operation codes 5 to 7 leave the counter unchanged, report `taken_o`=0 and `next_pc_o`=`pc_i`+1, and still complete with the R2 timing.
- R10: Operand inputs are used only as sampled at the accepting edge. `taken_o` and `next_pc_o` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Issue request for one operation |
| op_i | input | 3 | Operation code |
| cond_i | input | 2 | Branch condition code |
| arg_i | input | 16 | Immediate / threshold operand |
| rel_i | input | 8 | Signed relative branch offset in words |
| pc_i | input | 11 | Program counter of the issuing instruction |
| r0_i | input | 16 | Current value of R0 |
| busy_o | output | 1 | Operation in execution |
| done_o | output | 1 | One-cycle completion strobe |
| taken_o | output | 1 | Branch decision of the last completed operation |
| next_pc_o | output | 11 | Next program counter of the last completed operation |
| stage_cnt_o | output | 8 | Stage counter value |

## Verification
The hardest cases to reach from the ports are the exact-equality thresholds and the wrap points of the counter. Hitting them needs a counter value steered to a known point first. The stimulus therefore issues directed clear/add/subtract sequences that cross 255 and 0, then branches whose threshold equals, straddles or lies one away from the modelled counter. Random operations follow, and half of the random branches draw their threshold near the current model value. On every operation, extra `start_i` pulses with scrambled operands are driven during the busy window, and the operand inputs are scrambled after acceptance. This shows that only the accepted request has any effect.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [2:0] {
    OP_SCLR = 3'd0,
    OP_SADD = 3'd1,
    OP_SSUB = 3'd2,
    OP_BSTG = 3'd3,
    OP_BR0  = 3'd4
  } scb_op_e;

  typedef enum logic [1:0] {
    SC_LT = 2'd0,
    SC_GT = 2'd1,
    SC_LE = 2'd2,
    SC_EQ = 2'd3
  } scb_scond_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EX1  = 2'd1,
    PH_EX2  = 2'd2
  } scb_phase_e;

endpackage

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [1:0]        cond,
  input  logic [DATA_W-1:0] arg,
  input  logic [OFS_W-1:0]  rel,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] r0,
  output logic              busy,
  output logic              commit,
  output scb_op_e           op_q,
  output logic [1:0]        cond_q,
  output logic [DATA_W-1:0] arg_q,
  output logic [OFS_W-1:0]  rel_q,
  output logic [PC_W-1:0]   pc_q,
  output logic [DATA_W-1:0] r0_q
);

  scb_phase_e phase, phase_d;
  logic       accept;

  assign accept = start && (phase == PH_IDLE);
  assign busy   = (phase != PH_IDLE);
  assign commit = (phase == PH_EX2);

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (accept) phase_d = PH_EX1;
      PH_EX1:  phase_d = PH_EX2;
      PH_EX2:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      op_q   <= OP_SCLR;
      cond_q <= '0;
      arg_q  <= '0;
      rel_q  <= '0;
      pc_q   <= '0;
      r0_q   <= '0;
    end else begin
      phase <= phase_d;
      if (accept) begin
        op_q   <= scb_op_e'(op);
        cond_q <= cond;
        arg_q  <= arg;
        rel_q  <= rel;
        pc_q   <= pc;
        r0_q   <= r0;
      end
    end
  end

  // R8: a request during execution leaves the captured operation untouched
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(arg_q) && $stable(pc_q) && $stable(rel_q)));

  // R2: an accepted request reaches the commit phase two edges later
  a_r2_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !commit));

endmodule

// File: rtl/scb_stage_cnt.sv
module scb_stage_cnt
  import scb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  scb_op_e          op,
  input  logic [CNT_W-1:0] amt,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt;
    if (commit) begin
      unique case (op)
        OP_SCLR: begin cnt_en = 1'b1; cnt_d = '0;        end
        OP_SADD: begin cnt_en = 1'b1; cnt_d = cnt + amt; end
        OP_SSUB: begin cnt_en = 1'b1; cnt_d = cnt - amt; end
        default: begin cnt_en = 1'b0; cnt_d = cnt;       end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  // R3: clear drives the counter to zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_SCLR) |=> (cnt == '0));

  // R4: add wraps modulo 2^CNT_W
  a_r4_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == OP_SADD) |=> (cnt == CNT_W'($past(cnt) + $past(amt))));

  // R9: the counter moves only on a committed counter operation
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit || (op != OP_SCLR && op != OP_SADD && op != OP_SSUB)) |=> $stable(cnt));

endmodule

// File: rtl/scb_branch.sv
module scb_branch
  import scb_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8,
  parameter int CNT_W  = 8
) (
  input  scb_op_e           op,
  input  logic [1:0]        cond,
  input  logic [DATA_W-1:0] arg,
  input  logic [OFS_W-1:0]  rel,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] r0,
  input  logic [CNT_W-1:0]  cnt,
  output logic              taken,
  output logic [PC_W-1:0]   target
);

  localparam int EXT_W = PC_W - OFS_W;

  logic [CNT_W-1:0] thr;
  logic [PC_W-1:0]  rel_ext;
  logic             stg_hit;
  logic             r0_hit;

  assign thr = arg[CNT_W-1:0];

  generate
    if (EXT_W > 0) begin : g_sext
      assign rel_ext = {{EXT_W{rel[OFS_W-1]}}, rel};
    end else begin : g_trunc
      assign rel_ext = rel[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (scb_scond_e'(cond))
      SC_LT:   stg_hit = (cnt <  thr);
      SC_GT:   stg_hit = (cnt >  thr);
      SC_LE:   stg_hit = (cnt <= thr);
      SC_EQ:   stg_hit = (cnt == thr);
      default: stg_hit = 1'b0;
    endcase
  end

  assign r0_hit = cond[0] ? (r0 >= arg) : (r0 < arg);

  always_comb begin
    unique case (op)
      OP_BSTG: taken = stg_hit;
      OP_BR0:  taken = r0_hit;
      default: taken = 1'b0;
    endcase
  end

  assign target = taken ? (pc + rel_ext) : (pc + PC_W'(1));

endmodule

// File: rtl/scb_unit.sv
module scb_unit
  import scb_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        cond_i,
  input  logic [DATA_W-1:0] arg_i,
  input  logic [OFS_W-1:0]  rel_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] r0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [CNT_W-1:0]  stage_cnt_o
);

  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  logic              commit;
  scb_op_e           op_q;
  logic [1:0]        cond_q;
  logic [DATA_W-1:0] arg_q;
  logic [OFS_W-1:0]  rel_q;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] r0_q;
  logic              br_taken;
  logic [PC_W-1:0]   br_target;

  scb_ctrl #(.PC_W(PC_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) i_ctrl (
    .clk(clk_i), .rst_n(rst_n), .start(start_i), .op(op_i), .cond(cond_i),
    .arg(arg_i), .rel(rel_i), .pc(pc_i), .r0(r0_i), .busy(busy_o),
    .commit(commit), .op_q(op_q), .cond_q(cond_q), .arg_q(arg_q),
    .rel_q(rel_q), .pc_q(pc_q), .r0_q(r0_q)
  );

  scb_stage_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk_i), .rst_n(rst_n), .commit(commit), .op(op_q),
    .amt(arg_q[CNT_W-1:0]), .cnt(stage_cnt_o)
  );

  scb_branch #(.PC_W(PC_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) i_br (
    .op(op_q), .cond(cond_q), .arg(arg_q), .rel(rel_q), .pc(pc_q),
    .r0(r0_q), .cnt(stage_cnt_o), .taken(br_taken), .target(br_target)
  );

  logic            done_d;
  logic            taken_d;
  logic [PC_W-1:0] npc_d;

  always_comb begin
    done_d  = commit;
    taken_d = taken_o;
    npc_d   = next_pc_o;
    if (commit) begin
      taken_d = br_taken;
      npc_d   = br_target;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      done_o    <= done_d;
      taken_o   <= taken_d;
      next_pc_o <= npc_d;
    end
  end

  // R2: completion strobe lasts one cycle
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: a not-taken completion points at the following word
  a_r7_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !taken_o) |-> (next_pc_o == PC_W'(pc_q + PC_W'(1))));

  // R10: results only change on a completion
  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !commit |=> ($stable(taken_o) && $stable(next_pc_o)));

endmodule

// File: tb/test_scb_unit.sv
module test_scb_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [1:0]  cond;
  logic [15:0] arg;
  logic [7:0]  rel;
  logic [10:0] pc;
  logic [15:0] r0;
  logic        busy, done, taken;
  logic [10:0] next_pc;
  logic [7:0]  stage_cnt;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_cnt;
  logic       m_taken;
  logic [10:0] m_npc;

  scb_unit i_scb_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .cond_i(cond),
    .arg_i(arg), .rel_i(rel), .pc_i(pc), .r0_i(r0), .busy_o(busy),
    .done_o(done), .taken_o(taken), .next_pc_o(next_pc), .stage_cnt_o(stage_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_taken(input logic [2:0] o, input logic [1:0] c,
                                 input logic [15:0] a, input logic [7:0] cnt, input logic [15:0] rr);
    if (o == 3'd3) begin
      case (c)
        2'd0: return cnt <  a[7:0];
        2'd1: return cnt >  a[7:0];
        2'd2: return cnt <= a[7:0];
        default: return cnt == a[7:0];
      endcase
    end
    if (o == 3'd4) return c[0] ? (rr >= a) : (rr < a);
    return 1'b0;
  endfunction

  function automatic logic [10:0] f_npc(input bit t, input logic [10:0] p, input logic [7:0] r);
    logic [10:0] ext;
    ext = {{3{r[7]}}, r};
    return t ? (p + ext) : (p + 11'd1);
  endfunction

  function automatic logic [7:0] f_cnt(input logic [2:0] o, input logic [15:0] a, input logic [7:0] cnt);
    case (o)
      3'd0: return 8'd0;
      3'd1: return cnt + a[7:0];
      3'd2: return cnt - a[7:0];
      default: return cnt;
    endcase
  endfunction

  task automatic scramble();
    op   = 3'($urandom);
    cond = 2'($urandom);
    arg  = 16'($urandom);
    rel  = 8'($urandom);
    pc   = 11'($urandom);
    r0   = 16'($urandom);
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] c, input logic [15:0] a,
                       input logic [7:0] r, input logic [10:0] p, input logic [15:0] rr,
                       input bit junk);
    string tag;
    m_taken = f_taken(o, c, a, m_cnt, rr);
    m_npc   = f_npc(m_taken, p, r);
    m_cnt   = f_cnt(o, a, m_cnt);
    case (o)
      3'd0: tag = "R3";
      3'd1, 3'd2: tag = "R4";
      3'd3: tag = "R5";
      3'd4: tag = "R6";
      default: tag = "R9";
    endcase
    chk(busy == 1'b0, "R2 idle before issue", 32'(busy), 0);
    start = 1'b1; op = o; cond = c; arg = a; rel = r; pc = p; r0 = rr;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy cycle 1", 32'(busy), 1);
    start = junk;              // R8: requests during busy are ignored
    scramble();                // R10: operands used only as sampled
    @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0, "R2 busy cycle 2", {busy, done}, 32'h2);
    scramble();
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R2 done", {busy, done}, 32'h1);
    chk(taken == m_taken, {tag, junk ? " R8" : "", " taken"}, 32'(taken), 32'(m_taken));
    chk(next_pc == m_npc, {"R7 ", tag, " next_pc"}, 32'(next_pc), 32'(m_npc));
    chk(stage_cnt == m_cnt, {tag, junk ? " R8" : "", " counter"}, 32'(stage_cnt), 32'(m_cnt));
    @(negedge clk);
    chk(done == 1'b0, "R2 done single", 32'(done), 0);
    chk(taken == m_taken && next_pc == m_npc, "R10 hold", {taken, next_pc}, {m_taken, m_npc});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    op = '0; cond = '0; arg = '0; rel = '0; pc = '0; r0 = '0;
    m_cnt = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(stage_cnt == 8'd0 && busy == 1'b0 && done == 1'b0, "R1 reset", {stage_cnt, busy, done}, 0);
    chk(taken == 1'b0 && next_pc == 11'd0, "R1 reset results", {taken, next_pc}, 0);

    // Directed: counter wrap (R4), clear (R3)
    issue(3'd1, 2'd0, 16'h00C8, 8'h05, 11'd10, 16'd0, 1'b0);
    issue(3'd1, 2'd0, 16'hFF64, 8'h05, 11'd11, 16'd0, 1'b1);   // 200+100 -> 44
    issue(3'd2, 2'd0, 16'h0032, 8'h05, 11'd12, 16'd0, 1'b0);   // 44-50 -> 250
    issue(3'd2, 2'd0, 16'h00FF, 8'h05, 11'd13, 16'd0, 1'b1);
    issue(3'd0, 2'd0, 16'h1234, 8'h05, 11'h7FF, 16'd0, 1'b0);  // R3, pc wrap
    // Counter branch at equality and neighbours (R5)
    issue(3'd1, 2'd0, 16'd7, 8'h00, 11'd0, 16'd0, 1'b0);
    for (int c = 0; c < 4; c++) begin
      issue(3'd3, 2'(c), 16'd7, 8'hFF, 11'd0, 16'd0, 1'b1);    // taken -> 0x7FF
      issue(3'd3, 2'(c), 16'd6, 8'h10, 11'd100, 16'd0, 1'b0);
      issue(3'd3, 2'(c), 16'd8, 8'h80, 11'd100, 16'd0, 1'b0);
    end
    // R0 branch at equality and extremes (R6)
    issue(3'd4, 2'd0, 16'h8000, 8'h7F, 11'd50, 16'h8000, 1'b0);
    issue(3'd4, 2'd1, 16'h8000, 8'h7F, 11'd50, 16'h8000, 1'b1);
    issue(3'd4, 2'd0, 16'hFFFF, 8'h81, 11'd50, 16'hFFFE, 1'b0);
    issue(3'd4, 2'd3, 16'h0000, 8'h81, 11'd50, 16'h0000, 1'b0);
    // Unused codes (R9)
    issue(3'd5, 2'd3, 16'h0001, 8'h01, 11'd20, 16'd0, 1'b0);
    issue(3'd7, 2'd0, 16'h00FF, 8'h01, 11'd21, 16'hFFFF, 1'b1);

    // Random mix
    for (int i = 0; i < 500; i++) begin
      logic [2:0]  o;
      logic [15:0] a;
      o = 3'($urandom_range(0, 7));
      a = 16'($urandom);
      if (o == 3'd3 && $urandom_range(0, 1) == 1)
        a = {8'($urandom), m_cnt + 8'($signed(3'($urandom)))};
      issue(o, 2'($urandom), a, 8'($urandom), 11'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule